// File: doc/BRIEF.md
# Center-Aligned Three-Phase Gate Generator

This block drives the six switches of a three-leg voltage-source inverter. A modulator upstream provides the sector number (1 to 6) of the reference vector and three dwell times: the time spent on each of the two bounding active vectors and the total zero-vector time. The block produces the upper and lower gate signal for each leg, plus a strobe that marks the start of every switching period.

An up/down carrier sets the switching period. It rises from 0 to a programmed half-period value `H` and falls back to 0, so one period lasts `2*H` clock cycles. From the sector and the dwell times the block derives one compare threshold per leg. A leg's ideal state is high while the carrier is at or above its threshold, which centres every pulse on the carrier peak. Each half-period therefore runs from the all-low zero state, through the two active states, to the all-high zero state. In even sectors the two active states swap places, so only one leg changes at each transition.

The ideal state of each leg is split into a complementary pair. Every turn-on edge is held back by a programmed dead time. A per-leg counter measures how long the ideal state has been stable, and a comparator checks that time against the dead-time value. The half-period, the thresholds and the dead time are captured when the carrier is at zero. A new setting therefore takes effect at the next period boundary.

Top module: `svpwm_gate_gen`

## Requirements
- R1: While `rst` is high or `en` is low, all six gate outputs and `period_start` are low.
- R2: With `en` high, `period_start` pulses for one cycle exactly every `2*H` cycles, where `H` is the `half_period` value (at least 1). `half_period` is captured at the carrier zero point.
- R3: With `z = floor(dwell_t0/2)`, the thresholds are `z` for the leg that switches first, `z+T` for the leg that switches second, and `z+dwell_t1+dwell_t2` for the leg that switches last. The legs in first, second, last order are: sector 1 A,B,C; sector 2 B,A,C; sector 3 B,C,A; sector 4 C,B,A; sector 5 C,A,B; sector 6 A,C,B. Leg A is bit 0 and leg C is bit 2 of each gate bus.
- R4: In odd sectors `T` is `dwell_t1`; in even sectors `T` is `dwell_t2`, because the active-vector order is reversed there.
- R5: For a threshold `th` with `1 <= th <= H`, the ideal high time per period is `L = 2*(H-th)+1`. The upper gate of that leg is then high for `L - D` cycles per period, where `D` is `dead_time`.
- R6: The lower gate of a leg is high for `2*H - L - D` cycles per period.
- R7: A pulse whose ideal length is not greater than `D` leaves its gate low for the whole period. This applies to the upper and the lower gate alike.
- R8: The upper and lower gate of a leg are never high in the same cycle. With `D` nonzero, neither gate of a leg rises in the cycle right after the other gate was high.
- R9: A sector value of 0 or 7 holds every upper gate low and every lower gate continuously high. A threshold above `H` has the same effect on its leg.
- R10: A threshold of 0 holds the upper gate of its leg continuously high and its lower gate low.
- R11: With `D = 0`, the upper and lower high times of each leg sum to exactly `2*H` per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the gates off and the carrier at zero |
| sector | input | 3 | Sector of the reference vector, 1 to 6 |
| dwell_t1 | input | CNT_W | Cycles per half-period on the lower-numbered active vector |
| dwell_t2 | input | CNT_W | Cycles per half-period on the higher-numbered active vector |
| dwell_t0 | input | CNT_W | Total zero-vector cycles per half-period |
| half_period | input | CNT_W | Carrier peak value H; the period is 2*H cycles |
| dead_time | input | DT_W | Turn-on delay in cycles |
| gate_hi | output | 3 | Upper gates, legs A..C |
| gate_lo | output | 3 | Lower gates, legs A..C |
| period_start | output | 1 | One-cycle strobe at each carrier zero |

## Verification
The bench builds the block with an 8-bit carrier and a 6-bit dead-time counter. The narrow dead-time counter saturates at 63, so a leg that stays constant for a whole period runs its counter into saturation, and the continuous-gate cases of R9 and R10 depend on that. The 8-bit carrier keeps periods between 50 and 80 cycles. This makes room for every sector, a short pulse below the dead time, a period change and a zero dead time in a short run.

// File: rtl/svg_pkg.sv
package svg_pkg;

    localparam int unsigned NLEG = 3;

    typedef enum logic [1:0] {
        LEG_A = 2'd0,
        LEG_B = 2'd1,
        LEG_C = 2'd2
    } leg_e;

    // Order in which legs rise during the up-count of the carrier
    typedef struct packed {
        leg_e first;
        leg_e second;
        leg_e last;
    } leg_order_t;

    function automatic logic sector_ok(input logic [2:0] s);
        return (s >= 3'd1) && (s <= 3'd6);
    endfunction

    function automatic leg_order_t sector_order(input logic [2:0] s);
        leg_order_t o;
        case (s)
            3'd1:    o = '{LEG_A, LEG_B, LEG_C};
            3'd2:    o = '{LEG_B, LEG_A, LEG_C};
            3'd3:    o = '{LEG_B, LEG_C, LEG_A};
            3'd4:    o = '{LEG_C, LEG_B, LEG_A};
            3'd5:    o = '{LEG_C, LEG_A, LEG_B};
            3'd6:    o = '{LEG_A, LEG_C, LEG_B};
            default: o = '{LEG_A, LEG_B, LEG_C};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/svg_carrier.sv
module svg_carrier #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] half_in,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] half_q,
    output logic             at_zero
);
    logic             up_q;
    logic [CNT_W-1:0] half_eff;

    assign at_zero  = en && (cnt == '0);
    assign half_eff = (cnt == '0) ? half_in : half_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt    <= '0;
            up_q   <= 1'b1;
            half_q <= '0;
        end else if (up_q) begin
            cnt <= cnt + CNT_W'(1);
            if (cnt + CNT_W'(1) == half_eff) up_q <= 1'b0;
            if (cnt == '0) half_q <= half_in;
        end else begin
            cnt <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) up_q <= 1'b1;
        end
    end
endmodule

// File: rtl/svg_thresh.sv
module svg_thresh
    import svg_pkg::*;
#(
    parameter int unsigned CNT_W = 12,
    localparam int unsigned TH_W = CNT_W + 2
) (
    input  logic [2:0]                 sector,
    input  logic [CNT_W-1:0]           t1,
    input  logic [CNT_W-1:0]           t2,
    input  logic [CNT_W-1:0]           t0,
    output logic [NLEG-1:0][TH_W-1:0]  th,
    output logic                       valid
);
    leg_order_t      ord;
    logic [TH_W-1:0] z, mid, fin;

    always_comb begin
        ord   = sector_order(sector);
        valid = sector_ok(sector);
        z     = TH_W'(t0 >> 1);
        mid   = z + TH_W'(sector[0] ? t1 : t2);
        fin   = z + TH_W'(t1) + TH_W'(t2);
        th    = '0;
        th[ord.first]  = z;
        th[ord.second] = mid;
        th[ord.last]   = fin;
    end
endmodule

// File: rtl/svg_deadband.sv
module svg_deadband #(
    parameter int unsigned DT_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            ideal,
    input  logic [DT_W-1:0] dt,
    output logic            hi,
    output logic            lo
);
    logic            ideal_q;
    logic [DT_W-1:0] stable_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ideal_q  <= 1'b0;
            stable_q <= '0;
            hi       <= 1'b0;
            lo       <= 1'b0;
        end else begin
            ideal_q <= ideal;
            if (ideal != ideal_q)    stable_q <= '0;
            else if (stable_q != '1) stable_q <= stable_q + DT_W'(1);
            hi <= ideal_q  && (stable_q >= dt);
            lo <= !ideal_q && (stable_q >= dt);
        end
    end
endmodule

// File: rtl/svpwm_gate_gen.sv
module svpwm_gate_gen
    import svg_pkg::*;
#(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned DT_W  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [2:0]       sector,
    input  logic [CNT_W-1:0] dwell_t1,
    input  logic [CNT_W-1:0] dwell_t2,
    input  logic [CNT_W-1:0] dwell_t0,
    input  logic [CNT_W-1:0] half_period,
    input  logic [DT_W-1:0]  dead_time,
    output logic [2:0]       gate_hi,
    output logic [2:0]       gate_lo,
    output logic             period_start
);
    localparam int unsigned TH_W = CNT_W + 2;

    logic [CNT_W-1:0]          carrier_cnt;
    logic [CNT_W-1:0]          carrier_half;
    logic                      at_zero;
    logic [NLEG-1:0][TH_W-1:0] th_next, th_q;
    logic                      valid_next, valid_q;
    logic [DT_W-1:0]           dt_q;
    logic [NLEG-1:0]           ideal;

    svg_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk(clk), .rst(rst), .en(en), .half_in(half_period),
        .cnt(carrier_cnt), .half_q(carrier_half), .at_zero(at_zero)
    );

    svg_thresh #(.CNT_W(CNT_W)) u_thresh (
        .sector(sector), .t1(dwell_t1), .t2(dwell_t2), .t0(dwell_t0),
        .th(th_next), .valid(valid_next)
    );

    // Shadow registers: new settings only at the carrier zero point
    always_ff @(posedge clk) begin
        if (rst) begin
            th_q         <= '1;
            valid_q      <= 1'b0;
            dt_q         <= '0;
            period_start <= 1'b0;
        end else begin
            period_start <= at_zero;
            if (at_zero) begin
                th_q    <= th_next;
                valid_q <= valid_next;
                dt_q    <= dead_time;
            end
        end
    end

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        assign ideal[g] = en && valid_q && (TH_W'(carrier_cnt) >= th_q[g]);

        svg_deadband #(.DT_W(DT_W)) u_db (
            .clk(clk), .rst(rst), .en(en), .ideal(ideal[g]), .dt(dt_q),
            .hi(gate_hi[g]), .lo(gate_lo[g])
        );
    end
endmodule

// File: rtl/svpwm_gate_gen_chk.sv
module svpwm_gate_gen_chk #(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned DT_W  = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [2:0]       gate_hi,
    input logic [2:0]       gate_lo,
    input logic             period_start,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] half_q,
    input logic [DT_W-1:0]  dt_q
);
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !en |=> (gate_hi == 3'b0 && gate_lo == 3'b0 && !period_start)); // R1

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        period_start |=> !period_start); // R2

    AST_CARRIER_BOUND: assert property (@(posedge clk) disable iff (rst)
        en && half_q != '0 |-> cnt <= half_q); // R2

    AST_LEG_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (gate_hi & gate_lo) == 3'b0); // R8

    AST_HI_GAP: assert property (@(posedge clk) disable iff (rst)
        $past(dt_q) != '0 |-> (gate_hi & ~$past(gate_hi) & $past(gate_lo)) == 3'b0); // R8

    AST_LO_GAP: assert property (@(posedge clk) disable iff (rst)
        $past(dt_q) != '0 |-> (gate_lo & ~$past(gate_lo) & $past(gate_hi)) == 3'b0); // R8
endmodule

bind svpwm_gate_gen svpwm_gate_gen_chk #(.CNT_W(CNT_W), .DT_W(DT_W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .period_start(period_start), .cnt(carrier_cnt), .half_q(carrier_half),
    .dt_q(dt_q)
);

// File: tb/tb_svpwm_gate_gen.sv
module tb_svpwm_gate_gen;
    localparam int CNT_W = 8;
    localparam int DT_W  = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic [2:0]       sector = 3'd1;
    logic [CNT_W-1:0] dwell_t1 = '0, dwell_t2 = '0, dwell_t0 = '0;
    logic [CNT_W-1:0] half_period = 8'd40;
    logic [DT_W-1:0]  dead_time = '0;
    logic [2:0]       gate_hi, gate_lo;
    logic             period_start;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        int    hi[3];
        int    lo[3];
        int    h;
        string tag;
    } exp_t;

    exp_t q[$];
    bit   mon_idle = 1;

    svpwm_gate_gen #(.CNT_W(CNT_W), .DT_W(DT_W)) dut (
        .clk(clk), .rst(rst), .en(en), .sector(sector),
        .dwell_t1(dwell_t1), .dwell_t2(dwell_t2), .dwell_t0(dwell_t0),
        .half_period(half_period), .dead_time(dead_time),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .period_start(period_start)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Expected per-period high times from the requirement formulas
    function automatic exp_t model(input int s, input int t1, input int t2,
                                   input int t0, input int h, input int d,
                                   input string tag);
        exp_t e;
        int th[3];
        int f, m, l, z, len;
        z = t0 / 2;
        case (s)
            1: begin f = 0; m = 1; l = 2; end
            2: begin f = 1; m = 0; l = 2; end
            3: begin f = 1; m = 2; l = 0; end
            4: begin f = 2; m = 1; l = 0; end
            5: begin f = 2; m = 0; l = 1; end
            default: begin f = 0; m = 2; l = 1; end
        endcase
        th[f] = z;
        th[m] = z + ((s % 2 == 1) ? t1 : t2);
        th[l] = z + t1 + t2;
        e.h = h;
        e.tag = tag;
        for (int i = 0; i < 3; i++) begin
            if (s < 1 || s > 6 || th[i] > h) len = 0;
            else if (th[i] == 0)             len = 2 * h;
            else                             len = 2 * (h - th[i]) + 1;
            if (len == 2 * h)  e.hi[i] = 2 * h;
            else               e.hi[i] = (len > d) ? len - d : 0;
            if (len == 0)      e.lo[i] = 2 * h;
            else               e.lo[i] = (2 * h - len > d) ? 2 * h - len - d : 0;
        end
        return e;
    endfunction

    task automatic run_case(input int s, input int t1, input int t2, input int t0,
                            input int h, input int d, input string tag);
        @(negedge clk);
        sector = 3'(s); dwell_t1 = CNT_W'(t1); dwell_t2 = CNT_W'(t2);
        dwell_t0 = CNT_W'(t0); half_period = CNT_W'(h); dead_time = DT_W'(d);
        for (int k = 0; k < 3; k++) begin
            do tick(); while (!period_start);
        end
        q.push_back(model(s, t1, t2, t0, h, d, tag));
        mon_idle = 0;
        wait (mon_idle);
    endtask

    // Monitor: pops an expected item, measures one full period
    initial begin
        forever begin
            exp_t e;
            int hc[3], lc[3], strobes, overlap;
            wait (q.size() > 0);
            e = q.pop_front();
            do tick(); while (!period_start);
            hc = '{0, 0, 0}; lc = '{0, 0, 0}; strobes = 0; overlap = 0;
            for (int n = 0; n < 2 * e.h; n++) begin
                if (n > 0) tick();
                for (int i = 0; i < 3; i++) begin
                    hc[i] += int'(gate_hi[i]);
                    lc[i] += int'(gate_lo[i]);
                end
                strobes += int'(period_start);
                if ((gate_hi & gate_lo) != 3'b0) overlap++;
            end
            for (int i = 0; i < 3; i++) begin
                check($sformatf("%s R5 upper leg %0d", e.tag, i), hc[i], e.hi[i]);
                check($sformatf("%s R6 lower leg %0d", e.tag, i), lc[i], e.lo[i]);
            end
            check({e.tag, " R8 overlap cycles"}, overlap, 0);
            check({e.tag, " R2 strobes in period"}, strobes, 1);
            tick();
            check({e.tag, " R2 strobe at 2H"}, int'(period_start), 1);
            mon_idle = 1;
        end
    end

    initial begin
        repeat (3) tick();
        check("R1 reset gates", int'({gate_hi, gate_lo}), 0);
        check("R1 reset strobe", int'(period_start), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (5) tick();
        check("R1 disabled gates", int'({gate_hi, gate_lo}), 0);
        @(negedge clk);
        en = 1'b1;

        run_case(1, 10, 6, 24, 40, 3, "R3 sector1");
        run_case(2, 10, 6, 24, 40, 3, "R4 sector2");
        run_case(3, 10, 6, 24, 40, 3, "R3 sector3");
        run_case(4, 10, 6, 24, 40, 3, "R4 sector4");
        run_case(5, 9, 13, 18, 40, 4, "R3 sector5");
        run_case(6, 9, 13, 18, 40, 4, "R4 sector6");
        run_case(1, 20, 7, 24, 40, 5, "R7 short pulse");
        run_case(7, 10, 6, 24, 40, 3, "R9 sector7");
        run_case(0, 10, 6, 24, 40, 3, "R9 sector0");
        run_case(1, 30, 10, 0, 40, 3, "R10 zero threshold");
        run_case(3, 12, 5, 20, 40, 0, "R11 no dead time");
        run_case(1, 8, 4, 12, 25, 2, "R2 new period");

        @(negedge clk);
        en = 1'b0;
        begin
            int seen = 0;
            tick();
            for (int n = 0; n < 10; n++) begin
                tick();
                seen += int'(gate_hi != 0) + int'(gate_lo != 0) + int'(period_start);
            end
            check("R1 enable low", seen, 0);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule